// File: doc/BRIEF.md
# Resource-Aware Warp Issue Scheduler

This block is the issue stage of one multiprocessor. It holds up to four resident warps in an active pool and, on each clock, sends at most one warp instruction to one of three pipelined execution classes: a full-width arithmetic class (32 lanes), a half-width memory class (16 lanes) and a narrow transcendental class (4 lanes). An instruction whose class covers fewer lanes than the 32 threads of a warp goes out as a run of lane slices, one slice per clock. The warp that started the run keeps the issue slot until its last slice has gone out.

Warps arrive over a valid/ready feed. Each warp carries a flat warp number and a short program made only of class tags. A block of any shape is treated as a plain list of such warps. When a warp reaches its end tag, it retires with a one-cycle completion pulse. Its slot then becomes free and the next pending warp can fill it, so warps can finish in any order. Datapaths, operands and memory are outside this block.

Top module: `wsIssueSched`

## Requirements
- R1: While reset is held and after it is released, with no warp loaded, `issueValid` and `doneValid` are low and `pendReady` is high.
- R2: A tag 2'b00 (arithmetic) issues once, with `issueClass` 2'b00 and `issueLane` 0.
- R3: A tag 2'b01 (memory) issues in two back-to-back passes, with `issueClass` 2'b01 and `issueLane` 0 then 16.
- R4: A tag 2'b10 (transcendental) issues in eight back-to-back passes, with `issueClass` 2'b10 and `issueLane` 0, 4, 8 and so on up to 28.
- R5: A program holds up to eight tags, with tag i at bits [2i+1:2i] of `pendProg`. Tags issue in program order. When the needed class is ready, the next pass appears on the clock after the previous one, and the first pass appears two clocks after the warp is accepted.
- R6: A pass never issues while `resReady` for its class is low. Bit 0 is arithmetic, bit 1 memory, bit 2 transcendental. A stalled slice is held and resumes at the same lane index.
- R7: While a multi-pass instruction is in progress, no other warp issues, even if its class is ready.
- R8: Among warps that can issue, the choice is round-robin and starts at the slot after the one that issued last.
- R9: Tag 2'b11, or running past eight tags, ends the program. `doneValid` pulses for one cycle with the warp number, one clock after the final pass. A program that begins with 2'b11 retires two clocks after it is accepted and issues nothing.
- R10: The pool holds four warps. `pendReady` is low while all four slots are in use, and a pending warp is accepted once a resident warp has retired.
- R11: At most one pass issues per clock, and only from a resident warp whose current tag is not an end tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pendValid | input | 1 | A pending warp is offered |
| pendWarp | input | WID_W | Flat warp number of the offered warp |
| pendProg | input | 2*MAX_INSTR | Class-tag program of the offered warp |
| pendReady | output | 1 | A slot is free; an offered warp is taken this clock |
| resReady | input | 3 | Per-class accept enable (bit 0 arith, 1 memory, 2 transcendental) |
| issueValid | output | 1 | An issue pass is reported this cycle |
| issueWarp | output | WID_W | Warp number of the pass |
| issueClass | output | 2 | Class code of the pass |
| issueLane | output | $clog2(WARP_SIZE) | First lane covered by the pass |
| doneValid | output | 1 | One-cycle retirement pulse |
| doneWarp | output | WID_W | Warp number that retired |

## Verification
A table of single-warp programs gives the lane sequence and timing of each class on its own and in mixes. Mixed programs that move between narrow and wide classes show whether the per-instruction pass count and the program counter stay in step. A program of eight tags with no terminator tests the implicit end. Two-warp runs tell the fair rotation (two arithmetic warps alternating) apart from slice ownership (an arithmetic warp waiting behind an eight-pass run). Dropping a class ready before the first slice and again between slices separates gating at the start from holding a slice mid-run. Filling all four slots while the classes are blocked, then releasing them, shows the back-pressure and the refill.

// File: rtl/wsPkg.sv
package wsPkg;

  // Class tags carried by the abstract instruction stream
  typedef enum logic [1:0] {
    TAG_ALU = 2'b00,
    TAG_LSU = 2'b01,
    TAG_SFU = 2'b10,
    TAG_END = 2'b11
  } tagE;

  // Field widths of the control-to-datapath strobe bundle
  localparam int SLOT_IDX_W = 3;   // up to 8 pool slots
  localparam int LANE_IDX_W = 8;   // up to 256 lanes per warp

  typedef struct packed {
    logic                  issueEn;
    logic [SLOT_IDX_W-1:0] issueSlot;
    tagE                   issueCls;
    logic [LANE_IDX_W-1:0] laneStart;
    logic                  lastSlice;
    logic                  retireEn;
    logic [SLOT_IDX_W-1:0] retireSlot;
    logic                  loadEn;
    logic [SLOT_IDX_W-1:0] loadSlot;
  } strobeT;

endpackage

// File: rtl/wsCtrl.sv
module wsCtrl
  import wsPkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int WARP_SIZE = 32,
  parameter int LANES_ALU = 32,
  parameter int LANES_LSU = 16,
  parameter int LANES_SFU = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendValid,
  input  logic [2:0] resReady,
  input  logic       slotValid [NSLOT],
  input  tagE        curTag    [NSLOT],
  output logic       pendReady,
  output strobeT     st
);

  localparam int SW    = $clog2(NSLOT);
  localparam int MIN_L = (LANES_SFU < LANES_LSU)
                         ? ((LANES_SFU < LANES_ALU) ? LANES_SFU : LANES_ALU)
                         : ((LANES_LSU < LANES_ALU) ? LANES_LSU : LANES_ALU);
  localparam int MAXP  = WARP_SIZE / MIN_L;
  localparam int PW    = $clog2(MAXP + 1);

  function automatic int lanesOf(tagE t);
    case (t)
      TAG_ALU: return LANES_ALU;
      TAG_LSU: return LANES_LSU;
      TAG_SFU: return LANES_SFU;
      default: return WARP_SIZE;
    endcase
  endfunction

  function automatic logic readyOf(tagE t, logic [2:0] r);
    case (t)
      TAG_ALU: return r[0];
      TAG_LSU: return r[1];
      TAG_SFU: return r[2];
      default: return 1'b0;
    endcase
  endfunction

  // Issue state: multi-pass ownership, slice counter, round-robin pointer
  logic          lockActive;
  logic [SW-1:0] lockSlot;
  logic [SW-1:0] lastSlot;
  logic [PW-1:0] sliceIdx;

  logic [NSLOT-1:0] elig;
  logic [SW-1:0]    pick;
  logic             pickOk;
  int               slice;
  int               idx;
  tagE              cls;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      elig[i] = slotValid[i] && (curTag[i] != TAG_END) && readyOf(curTag[i], resReady);
    end

    pickOk = 1'b0;
    pick   = '0;
    idx    = 0;
    if (lockActive) begin
      pickOk = elig[lockSlot];
      pick   = lockSlot;
    end else begin
      for (int k = 1; k <= NSLOT; k++) begin
        idx = (int'(lastSlot) + k) % NSLOT;
        if (!pickOk && elig[idx]) begin
          pickOk = 1'b1;
          pick   = SW'(idx);
        end
      end
    end

    cls   = curTag[pick];
    slice = lockActive ? int'(sliceIdx) : 0;

    st            = '0;
    st.issueEn    = pickOk;
    st.issueSlot  = SLOT_IDX_W'(pick);
    st.issueCls   = cls;
    st.laneStart  = LANE_IDX_W'(slice * lanesOf(cls));
    st.lastSlice  = ((slice + 1) * lanesOf(cls)) >= WARP_SIZE;

    for (int i = 0; i < NSLOT; i++) begin
      if (!st.retireEn && slotValid[i] && (curTag[i] == TAG_END)) begin
        st.retireEn   = 1'b1;
        st.retireSlot = SLOT_IDX_W'(i);
      end
    end

    pendReady = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!pendReady && !slotValid[i]) begin
        pendReady   = 1'b1;
        st.loadSlot = SLOT_IDX_W'(i);
      end
    end
    st.loadEn = pendValid && pendReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockActive <= 1'b0;
      lockSlot   <= '0;
      lastSlot   <= SW'(NSLOT - 1);
      sliceIdx   <= '0;
    end else if (st.issueEn) begin
      lastSlot <= pick;
      if (st.lastSlice) begin
        lockActive <= 1'b0;
        sliceIdx   <= '0;
      end else begin
        lockActive <= 1'b1;
        lockSlot   <= pick;
        sliceIdx   <= PW'(slice + 1);
      end
    end
  end

  // R7: a stalled multi-pass run keeps its owner and its slice position
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lockActive && !st.issueEn) |=> (lockActive && $stable(lockSlot) && $stable(sliceIdx)));

  // R4: an open run always sits past its first slice and below the pass count
  p_slice_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |-> (sliceIdx != '0 && int'(sliceIdx) < MAXP));

endmodule

// File: rtl/wsPool.sv
module wsPool
  import wsPkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int WID_W     = 8,
  parameter int MAX_INSTR = 8,
  parameter int LANE_W    = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 st,
  input  logic [WID_W-1:0]       pendWarp,
  input  logic [2*MAX_INSTR-1:0] pendProg,
  output logic                   slotValid [NSLOT],
  output tagE                    curTag    [NSLOT],
  output logic                   issueValid,
  output logic [WID_W-1:0]       issueWarp,
  output logic [1:0]             issueClass,
  output logic [LANE_W-1:0]      issueLane,
  output logic                   doneValid,
  output logic [WID_W-1:0]       doneWarp
);

  localparam int SW     = $clog2(NSLOT);
  localparam int PROG_W = 2 * (MAX_INSTR + 1);
  localparam int PC_W   = $clog2(MAX_INSTR + 1);

  logic [WID_W-1:0]  warpId [NSLOT];
  logic [PROG_W-1:0] prog   [NSLOT];
  logic [PC_W-1:0]   pc     [NSLOT];

  logic [SW-1:0] issueIdx, retireIdx, loadIdx;
  assign issueIdx  = st.issueSlot[SW-1:0];
  assign retireIdx = st.retireSlot[SW-1:0];
  assign loadIdx   = st.loadSlot[SW-1:0];

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotValid[g] <= 1'b0;
          warpId[g]    <= '0;
          prog[g]      <= '1;
          pc[g]        <= '0;
        end else if (st.loadEn && (loadIdx == SW'(g))) begin
          slotValid[g] <= 1'b1;
          warpId[g]    <= pendWarp;
          prog[g]      <= {2'b11, pendProg};   // implicit terminator after the last tag
          pc[g]        <= '0;
        end else if (st.retireEn && (retireIdx == SW'(g))) begin
          slotValid[g] <= 1'b0;
        end else if (st.issueEn && st.lastSlice && (issueIdx == SW'(g))) begin
          pc[g] <= pc[g] + 1'b1;
        end
      end

      assign curTag[g] = tagE'(prog[g][2*pc[g] +: 2]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueValid <= 1'b0;
      issueWarp  <= '0;
      issueClass <= '0;
      issueLane  <= '0;
      doneValid  <= 1'b0;
      doneWarp   <= '0;
    end else begin
      issueValid <= st.issueEn;
      doneValid  <= st.retireEn;
      if (st.issueEn) begin
        issueWarp  <= warpId[issueIdx];
        issueClass <= st.issueCls;
        issueLane  <= st.laneStart[LANE_W-1:0];
      end
      if (st.retireEn) begin
        doneWarp <= warpId[retireIdx];
      end
    end
  end

  // R10: the control only ever fills a slot that is empty
  p_load_free_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.loadEn |-> !slotValid[loadIdx]);

  // R11: a pass is taken only from a resident warp with live work
  p_issue_live_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.issueEn |-> (slotValid[issueIdx] && curTag[issueIdx] != TAG_END));

  // R9: retirement touches only a resident warp that sits at its end tag
  p_retire_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.retireEn |-> (slotValid[retireIdx] && curTag[retireIdx] == TAG_END));

  // R9: a completion pulse is never repeated for the same warp
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid || doneWarp != $past(doneWarp)));

endmodule

// File: rtl/wsIssueSched.sv
module wsIssueSched
  import wsPkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int WID_W     = 8,
  parameter int MAX_INSTR = 8,
  parameter int WARP_SIZE = 32,
  parameter int LANES_ALU = 32,
  parameter int LANES_LSU = 16,
  parameter int LANES_SFU = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pendValid,
  input  logic [WID_W-1:0]             pendWarp,
  input  logic [2*MAX_INSTR-1:0]       pendProg,
  output logic                         pendReady,
  input  logic [2:0]                   resReady,
  output logic                         issueValid,
  output logic [WID_W-1:0]             issueWarp,
  output logic [1:0]                   issueClass,
  output logic [$clog2(WARP_SIZE)-1:0] issueLane,
  output logic                         doneValid,
  output logic [WID_W-1:0]             doneWarp
);

  localparam int LANE_W = $clog2(WARP_SIZE);

  strobeT st;
  logic   slotValid [NSLOT];
  tagE    curTag    [NSLOT];

  wsCtrl #(
    .NSLOT(NSLOT), .WARP_SIZE(WARP_SIZE),
    .LANES_ALU(LANES_ALU), .LANES_LSU(LANES_LSU), .LANES_SFU(LANES_SFU)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .resReady(resReady),
    .slotValid(slotValid), .curTag(curTag), .pendReady(pendReady), .st(st)
  );

  wsPool #(
    .NSLOT(NSLOT), .WID_W(WID_W), .MAX_INSTR(MAX_INSTR), .LANE_W(LANE_W)
  ) uPool (
    .clk(clk), .rstN(rstN), .st(st), .pendWarp(pendWarp), .pendProg(pendProg),
    .slotValid(slotValid), .curTag(curTag),
    .issueValid(issueValid), .issueWarp(issueWarp), .issueClass(issueClass),
    .issueLane(issueLane), .doneValid(doneValid), .doneWarp(doneWarp)
  );

  // R6: every reported pass had its class enabled on the clock it was taken
  p_class_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> ((issueClass == 2'b00 && $past(resReady[0])) ||
                    (issueClass == 2'b01 && $past(resReady[1])) ||
                    (issueClass == 2'b10 && $past(resReady[2]))));

endmodule

// File: tb/sim_wsIssueSched.sv
module sim_wsIssueSched;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pendValid;
  logic [7:0]  pendWarp;
  logic [15:0] pendProg;
  logic        pendReady;
  logic [2:0]  resReady;
  logic        issueValid;
  logic [7:0]  issueWarp;
  logic [1:0]  issueClass;
  logic [4:0]  issueLane;
  logic        doneValid;
  logic [7:0]  doneWarp;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  wsIssueSched u0 (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .pendWarp(pendWarp),
    .pendProg(pendProg), .pendReady(pendReady), .resReady(resReady),
    .issueValid(issueValid), .issueWarp(issueWarp), .issueClass(issueClass),
    .issueLane(issueLane), .doneValid(doneValid), .doneWarp(doneWarp)
  );

  // Single-warp programs (tag i at bits [2i+1:2i]) and their pass totals
  localparam int NVEC = 6;
  localparam logic [15:0] VEC_PROG [NVEC] = '{
    16'hFFFC,   // arith
    16'hFFFD,   // memory
    16'hFFFE,   // transcendental
    16'hFFE4,   // arith, memory, transcendental
    16'hFF12,   // transcendental, arith, memory, arith
    16'h0000    // eight arith, implicit end
  };
  localparam int VEC_PASSES [NVEC] = '{1, 2, 8, 11, 12, 8};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lanesFor(input logic [1:0] t);
    return (t == 2'b00) ? 32 : (t == 2'b01) ? 16 : 4;
  endfunction

  function automatic string reqFor(input logic [1:0] t);
    return (t == 2'b00) ? "R2" : (t == 2'b01) ? "R3" : "R4";
  endfunction

  task automatic offerAndLatch(input logic [7:0] id, input logic [15:0] prog);
    pendWarp  = id;
    pendProg  = prog;
    pendValid = 1'b1;
    @(negedge clk);
    pendValid = 1'b0;
    @(negedge clk);
  endtask

  // Expects the first pass visible now; walks all passes, then the pulse (R5, R9)
  task automatic walkProgram(input logic [7:0] id, input logic [15:0] prog, input int expPasses);
    int seen = 0;
    for (int t = 0; t < 8; t++) begin
      logic [1:0] tag = prog[2*t +: 2];
      if (tag == 2'b11) break;
      for (int p = 0; p < 32 / lanesFor(tag); p++) begin
        chk(issueValid && issueWarp == id && issueClass == tag && int'(issueLane) == p * lanesFor(tag),
            reqFor(tag), int'(issueLane), p * lanesFor(tag));
        seen++;
        @(negedge clk);
      end
    end
    chk(seen == expPasses, "R5", seen, expPasses);
    chk(doneValid && doneWarp == id && !issueValid, "R9", int'(doneWarp), int'(id));
    @(negedge clk);
    chk(!doneValid, "R9", int'(doneValid), 0);
  endtask

  initial begin
    #(10 * 150000);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    pendValid = 1'b0;
    pendWarp  = '0;
    pendProg  = '1;
    resReady  = 3'b111;
    repeat (3) @(negedge clk);
    chk(!issueValid && !doneValid && pendReady, "R1", int'(issueValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!issueValid && !doneValid && pendReady, "R1", int'(pendReady), 1);

    // Vector walk: one warp per program
    for (int v = 0; v < NVEC; v++) begin
      offerAndLatch(8'(v + 1), VEC_PROG[v]);
      walkProgram(8'(v + 1), VEC_PROG[v], VEC_PASSES[v]);
    end

    // R8: two arithmetic warps alternate
    pendWarp = 8'd5; pendProg = 16'hFFF0; pendValid = 1'b1;
    @(negedge clk);
    pendWarp = 8'd9;
    @(negedge clk);
    pendValid = 1'b0;
    chk(issueValid && issueWarp == 8'd5, "R8", int'(issueWarp), 5);
    @(negedge clk);
    chk(issueValid && issueWarp == 8'd9, "R8", int'(issueWarp), 9);
    @(negedge clk);
    chk(issueValid && issueWarp == 8'd5, "R8", int'(issueWarp), 5);
    @(negedge clk);
    chk(issueValid && issueWarp == 8'd9 && doneValid && doneWarp == 8'd5, "R8", int'(issueWarp), 9);
    @(negedge clk);
    chk(doneValid && doneWarp == 8'd9 && !issueValid, "R9", int'(doneWarp), 9);
    @(negedge clk);

    // R7: an arithmetic warp waits behind an eight-pass run
    pendWarp = 8'd3; pendProg = 16'hFFFE; pendValid = 1'b1;
    @(negedge clk);
    pendWarp = 8'd4; pendProg = 16'hFFFC;
    @(negedge clk);
    pendValid = 1'b0;
    for (int p = 0; p < 8; p++) begin
      chk(issueValid && issueWarp == 8'd3 && int'(issueLane) == 4 * p, "R7", int'(issueWarp), 3);
      @(negedge clk);
    end
    chk(issueValid && issueWarp == 8'd4 && issueClass == 2'b00 && doneValid && doneWarp == 8'd3,
        "R7", int'(issueWarp), 4);
    @(negedge clk);
    chk(doneValid && doneWarp == 8'd4, "R9", int'(doneWarp), 4);
    @(negedge clk);

    // R6: memory class gated before the first slice and between slices
    resReady = 3'b101;
    offerAndLatch(8'd7, 16'hFFFD);
    chk(!issueValid, "R6", int'(issueValid), 0);
    @(negedge clk);
    chk(!issueValid, "R6", int'(issueValid), 0);
    resReady = 3'b111;
    @(negedge clk);
    chk(issueValid && issueWarp == 8'd7 && issueLane == 5'd0, "R6", int'(issueLane), 0);
    resReady = 3'b101;
    @(negedge clk);
    chk(!issueValid, "R6", int'(issueValid), 0);
    resReady = 3'b111;
    @(negedge clk);
    chk(issueValid && issueClass == 2'b01 && issueLane == 5'd16, "R6", int'(issueLane), 16);
    @(negedge clk);
    chk(doneValid && doneWarp == 8'd7, "R9", int'(doneWarp), 7);
    @(negedge clk);

    // R9: empty program retires without a pass
    offerAndLatch(8'd11, 16'hFFFF);
    chk(doneValid && doneWarp == 8'd11 && !issueValid, "R9", int'(doneWarp), 11);
    @(negedge clk);
    chk(!doneValid && !issueValid, "R9", int'(doneValid), 0);

    // R10: fill the pool while every class is blocked, then release
    resReady = 3'b000;
    pendProg = 16'hFFFC;
    pendValid = 1'b1;
    for (int w = 0; w < 4; w++) begin
      pendWarp = 8'(20 + w);
      @(negedge clk);
    end
    pendWarp = 8'd24;
    chk(!pendReady, "R10", int'(pendReady), 0);
    @(negedge clk);
    chk(!pendReady && !issueValid, "R10", int'(pendReady), 0);
    resReady = 3'b111;
    begin
      int  doneCount = 0;
      bit  saw24 = 1'b0;
      bit  acceptNext = 1'b0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (doneValid) begin
          doneCount++;
          if (doneWarp == 8'd24) saw24 = 1'b1;
        end
        if (acceptNext) pendValid = 1'b0;
        acceptNext = pendValid && pendReady;
      end
      chk(doneCount == 5, "R10", doneCount, 5);
      chk(saw24, "R10", int'(saw24), 1);
      chk(pendReady && !issueValid, "R10", int'(pendReady), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule